// File: doc/BRIEF.md
# Prescaled UART Baud Rate Generator

This block produces the 16x oversampling enable for one UART channel. The input clock first passes through a prescaler that divides by 1 or by 4. A 16-bit programmable divisor then divides the prescaled rate, and the result is a single-cycle enable pulse. The UART's receive and transmit shifters use this pulse as their bit-timing reference. The output is never a derived clock.

The prescale choice comes from a board strap while reset is asserted. The strap value is stored inverted: a high strap selects divide-by-1, so the stored bit is 0. Software can later overwrite the stored bit through a control-register write. The divisor is written one byte at a time. Any write to a divisor byte or to the prescale bit restarts both counters, so a new rate takes effect at once and not only after the old period ends. A divisor of zero stops the pulse.

Top module: `uart_rate_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `tick16` is 0. The divisor resets to 0, so no pulse appears until software writes a divisor.
- R2: `pre_quarter` takes the inverse of `div1_strap` as sampled on the last clock edge with `rst` high. A high strap gives 0, which means divide-by-1. A low strap gives 1, which means divide-by-4.
- R3: When `pre_we` is high at a clock edge, `pre_quarter` takes `pre_wdata` after that edge.
- R4: With `pre_quarter` = 0 and divisor D > 0, `tick16` pulses once every D input cycles.
- R5: With `pre_quarter` = 1 and divisor D > 0, `tick16` pulses once every 4*D input cycles.
- R6: While the divisor is 0, `tick16` stays 0.
- R7: Any write to `div_lo_we`, `div_hi_we` or `pre_we` restarts the counting, and `tick16` is 0 on the cycle after the write. The first pulse is seen P*D edges after the write edge, where P is 1 or 4, and pulses then repeat every P*D cycles.
- R8: With divisor 1 and `pre_quarter` = 0, `tick16` is high on every cycle.
- R9: `div_lo_we` loads `div_wdata` into divisor bits 7:0, and `div_hi_we` loads it into bits 15:8. The other byte keeps its value.
- R10: Whenever the period P*D exceeds 1, `tick16` is high for exactly one cycle per pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| div1_strap | input | 1 | Prescale strap, captured during reset; high selects divide-by-1 |
| div_lo_we | input | 1 | Write strobe for the low divisor byte |
| div_hi_we | input | 1 | Write strobe for the high divisor byte |
| div_wdata | input | 8 | Divisor byte write data |
| pre_we | input | 1 | Write strobe for the prescale bit |
| pre_wdata | input | 1 | New prescale bit (1 = divide-by-4) |
| tick16 | output | 1 | One-cycle 16x oversampling enable |
| pre_quarter | output | 1 | Current prescale bit, readable by software |

## Verification
A reference model counts edges since the last restart and is compared with the design on every cycle. Divisor 1 without prescale shows whether the output is a continuous enable or a pulse train. Small divisors with and without the divide-by-4 stage show whether the prescaler sits ahead of the divisor. A divisor of 258 tells the low-byte and high-byte write paths apart.

A write in the middle of a period shows whether the counters restart or run on. Two resets, one with each strap level, show the inversion and the capture point of the strap.

// File: rtl/uart_rate_gen.sv
module uart_rate_gen #(
  parameter int DIV_W   = 16,
  parameter int BYTE_W  = 8,
  parameter int PRE_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              div1_strap,
  input  logic              div_lo_we,
  input  logic              div_hi_we,
  input  logic [BYTE_W-1:0] div_wdata,
  input  logic              pre_we,
  input  logic              pre_wdata,
  output logic              tick16,
  output logic              pre_quarter
);
  localparam int HI_W  = DIV_W - BYTE_W;
  localparam int PRE_W = $clog2(PRE_DIV);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] dcnt;
  logic [PRE_W-1:0] pcnt;

  wire reload    = div_lo_we | div_hi_we | pre_we;
  wire pre_pulse = !pre_quarter || (pcnt == PRE_W'(PRE_DIV - 1));
  wire last      = (dcnt == div_q - DIV_W'(1));
  wire div_nz    = |div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_quarter <= ~div1_strap;
      div_q       <= '0;
      pcnt        <= '0;
      dcnt        <= '0;
      tick16      <= 1'b0;
    end else begin
      if (pre_we)    pre_quarter <= pre_wdata;
      if (div_lo_we) div_q[BYTE_W-1:0] <= div_wdata;
      if (div_hi_we) div_q[DIV_W-1:BYTE_W] <= div_wdata[HI_W-1:0];
      if (reload) begin
        pcnt   <= '0;
        dcnt   <= '0;
        tick16 <= 1'b0;
      end else begin
        pcnt   <= (pre_quarter && !pre_pulse) ? pcnt + PRE_W'(1) : '0;
        if (pre_pulse) dcnt <= last ? '0 : dcnt + DIV_W'(1);
        tick16 <= pre_pulse && last && div_nz;
      end
    end
  end
endmodule

module uart_rate_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             div1_strap,
  input logic             div_lo_we,
  input logic             div_hi_we,
  input logic             pre_we,
  input logic             pre_wdata,
  input logic             tick16,
  input logic             pre_quarter,
  input logic [DIV_W-1:0] div_q
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !tick16);

  p_strap_inverted_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pre_quarter == !$past(div1_strap)));

  p_pre_write_r3: assert property (@(posedge clk) disable iff (rst)
    pre_we |=> (pre_quarter == $past(pre_wdata)));

  p_halt_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (div_q == '0) |=> !tick16);

  p_restart_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (div_lo_we || div_hi_we || pre_we) |=> !tick16);

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (tick16 && !(div_q == DIV_W'(1) && !pre_quarter)) |=> !tick16);
endmodule

bind uart_rate_gen uart_rate_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .div1_strap(div1_strap), .div_lo_we(div_lo_we),
  .div_hi_we(div_hi_we), .pre_we(pre_we), .pre_wdata(pre_wdata),
  .tick16(tick16), .pre_quarter(pre_quarter), .div_q(div_q)
);

// File: tb/uart_rate_gen_bench.sv
module uart_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       div1_strap = 1'b1;
  logic       div_lo_we = 1'b0;
  logic       div_hi_we = 1'b0;
  logic [7:0] div_wdata = 8'h00;
  logic       pre_we = 1'b0;
  logic       pre_wdata = 1'b0;
  logic       tick16;
  logic       pre_quarter;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit started = 0;
  bit done = 0;

  int m_div = 0;
  int m_cnt = 0;
  bit m_q = 0;
  bit m_tick = 0;

  always #2.5 clk = ~clk;

  uart_rate_gen u_uart_rate_gen (
    .clk(clk), .rst(rst), .div1_strap(div1_strap), .div_lo_we(div_lo_we),
    .div_hi_we(div_hi_we), .div_wdata(div_wdata), .pre_we(pre_we),
    .pre_wdata(pre_wdata), .tick16(tick16), .pre_quarter(pre_quarter)
  );

  // Model: edges since restart, pulse when that count is a multiple of P*D.
  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_q = !div1_strap;
      m_div = 0;
      m_cnt = 0;
      m_tick = 0;
    end else begin
      if (pre_we) m_q = pre_wdata;
      if (div_lo_we) m_div = (m_div & 32'hFF00) | int'(div_wdata);
      if (div_hi_we) m_div = (m_div & 32'h00FF) | (int'(div_wdata) << 8);
      if (div_lo_we || div_hi_we || pre_we) begin
        m_cnt = 0;
        m_tick = 0;
      end else begin
        int per;
        m_cnt++;
        per = (m_q ? 4 : 1) * m_div;
        m_tick = (per != 0) ? (m_cnt % per == 0) : 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (tick16 !== m_tick) begin
        errors++;
        $display("FAIL %s tick16 actual %b expected %b at %0t", phase, tick16, m_tick, $time);
      end
      checks++;
      if (pre_quarter !== m_q) begin
        errors++;
        $display("FAIL %s/R2/R3 pre_quarter actual %b expected %b at %0t",
                 phase, pre_quarter, m_q, $time);
      end
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_lo(input logic [7:0] v);
    @(negedge clk); div_lo_we = 1'b1; div_wdata = v;
    @(negedge clk); div_lo_we = 1'b0;
  endtask

  task automatic wr_hi(input logic [7:0] v);
    @(negedge clk); div_hi_we = 1'b1; div_wdata = v;
    @(negedge clk); div_hi_we = 1'b0;
  endtask

  task automatic wr_pre(input logic v);
    @(negedge clk); pre_we = 1'b1; pre_wdata = v;
    @(negedge clk); pre_we = 1'b0;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk); rst = 1'b1; div1_strap = strap;
    wait_cycles(3);
    rst = 1'b0;
    div1_strap = ~strap;  // strap changes after release must not matter (R2)
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired in phase %s", phase);
      finish_run();
    end
  end

  initial begin
    phase = "R1"; do_reset(1'b1); wait_cycles(10);   // R1 reset quiet, R6 divisor 0, R2 strap high
    phase = "R8"; wr_lo(8'd1); wait_cycles(12);      // R8 every cycle
    phase = "R4"; wr_lo(8'd5); wait_cycles(30);      // R4 and R10 single pulse
    phase = "R9"; wr_hi(8'd1); wr_lo(8'd2); wait_cycles(600);  // R9 divisor 258
    phase = "R5"; wr_hi(8'd0); wr_lo(8'd3); wr_pre(1'b1); wait_cycles(60);  // R5, R3
    phase = "R7"; wait_cycles(5); wr_lo(8'd7); wait_cycles(3); wr_hi(8'd0); wait_cycles(70);  // R7 restart
    phase = "R6"; wr_lo(8'd0); wait_cycles(40);      // R6 halt
    phase = "R2"; do_reset(1'b0); wait_cycles(5);    // R2 low strap gives divide-by-4
    wr_lo(8'd2); wait_cycles(30);
    phase = "R3"; wr_pre(1'b0); wait_cycles(20);     // R3 back to divide-by-1
    phase = "R10"; wr_lo(8'd1); wr_pre(1'b1); wait_cycles(20);  // R10 divide-by-4 with D=1
    finish_run();
  end
endmodule